// File: doc/BRIEF.md
# Data Port Memory Responder

This block sits on the memory side of a simple strobe/acknowledge data port. A requester raises a one-cycle strobe together with a write flag, a four-bit byte-lane mask, a word address and a 32-bit write word. The responder owns a word-organised RAM. It either returns the whole addressed word or updates only the selected byte lanes. It answers every accepted request with a one-cycle acknowledge pulse.

A runtime latency input adds 0 to 15 wait cycles before each answer. The protocol places no upper bound on this wait. With the overlap input low, only one request may be in flight, and a strobe that arrives while one is pending is dropped. With overlap high, a second request is queued behind the first. Both are answered in the order they arrived, and a strobe that arrives while two are pending is dropped.

Top module: `dpr_responder`

## Requirements
- R1: During reset, and after it, ack and read data are 0 and no request is pending. A request that is in flight when reset is asserted is never acknowledged.
- R2: A read returns all 32 bits of the addressed word in its ack cycle, whatever the byte-lane mask holds.
- R3: On a write, mask bit i enables byte lane i, which is data bits 8i+7 down to 8i. Lanes whose bit is 0 keep their old contents, and a mask of 0000 changes nothing.
- R4: Read data is 0 in every cycle without ack and in the ack cycle of a write. Each accepted request produces exactly one single-cycle ack.
- R5: With no request ahead of it, a request strobed in cycle s is acknowledged in cycle s+L+2, where L is the latency input.
- R6: With overlap low, a strobe that arrives while one request is pending is ignored. It produces no ack and no RAM write.
- R7: With overlap high, a second strobe that arrives while one request is pending is accepted. Acks come in request order, and the second ack follows the first after L+1 cycles.
- R8: With overlap high, a strobe that arrives while two requests are pending is ignored. It produces no ack and no RAM write.
- R9: A strobe that arrives in the ack cycle of the last pending request is accepted, even with overlap low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| overlap_en | input | 1 | 1 allows two pending requests, 0 allows one |
| latency | input | LAT_W (4) | Extra wait cycles before each answer |
| req_stb | input | 1 | One-cycle request strobe |
| req_we | input | 1 | 1 = write, 0 = read, taken with the strobe |
| req_bsel | input | 4 | Byte-lane mask |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (32) | Write word |
| rsp_ack | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | DATA_W (32) | Read word, valid with ack |

## Verification
The bench builds the block with its default parameters: 6 address bits (64 words), a 2-deep queue and a 4-bit latency input. The 64-word RAM lets the bench reach both the lowest used word and the top word (63). The 4-bit latency input lets it sweep the latency from 0 to its ceiling of 15. Because the queue is 2 deep, a third strobe can be issued and shown to be dropped. The latency also stretches the wait window, so both single and overlap timing can be measured to the exact cycle.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned lane_count(input int unsigned word_w);
    return word_w / BYTE_W;
  endfunction
endpackage

// File: rtl/dpr_req_fifo.sv
module dpr_req_fifo #(
  parameter type T = logic,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  T                 din,
  input  logic             pop,
  output T                 dout,
  output logic [LVL_W-1:0] level
);

  T                 slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d;
  logic [PTR_W-1:0] rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (push) wr_d = bump(wr_q);
    if (pop)  rd_d = bump(rd_q);
    if (push && !pop)      lvl_d = lvl_q + 1'b1;
    else if (pop && !push) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_q] <= din;
  end

  assign dout  = slot_q[rd_q];
  assign level = lvl_q;

endmodule

// File: rtl/dpr_lat_timer.sv
module dpr_lat_timer #(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [LAT_W-1:0] limit,
  output logic             due
);

  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  assign step_en = run && (cnt_q < limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (step_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign due = run && (cnt_q >= limit);

endmodule

// File: rtl/dpr_lane_ram.sv
module dpr_lane_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = lane_count(DATA_W),
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [WORDS];
    logic              lane_we;

    assign lane_we = wr_en && sel[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = mem[addr];
  end

endmodule

// File: rtl/dpr_responder.sv
module dpr_responder
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT_W  = 4,
  parameter int unsigned QDEPTH = 2,
  localparam int unsigned LANES = lane_count(DATA_W),
  localparam int unsigned LVL_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overlap_en,
  input  logic [LAT_W-1:0]  latency,
  input  logic              req_stb,
  input  logic              req_we,
  input  logic [LANES-1:0]  req_bsel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata
);

  typedef struct packed {
    logic              we;
    logic [LANES-1:0]  sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } req_t;

  req_t              in_req;
  req_t              head;
  logic [LVL_W-1:0]  q_level;
  logic [LVL_W-1:0]  cap;
  logic              accept;
  logic              head_valid;
  logic              serve;
  logic              ram_we;
  logic [DATA_W-1:0] ram_rdata;

  logic              ack_q, ack_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign in_req     = '{we: req_we, sel: req_bsel, addr: req_addr, data: req_wdata};
  assign cap        = overlap_en ? LVL_W'(QDEPTH) : LVL_W'(1);
  assign accept     = req_stb && (q_level < cap);
  assign head_valid = (q_level != '0);
  assign ram_we     = serve && head.we;

  dpr_req_fifo #(.T(req_t), .DEPTH(QDEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .din   (in_req),
    .pop   (serve),
    .dout  (head),
    .level (q_level)
  );

  dpr_lat_timer #(.LAT_W(LAT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (head_valid),
    .clear (serve),
    .limit (latency),
    .due   (serve)
  );

  dpr_lane_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .wr_en (ram_we),
    .addr  (head.addr),
    .sel   (head.sel),
    .wdata (head.data),
    .rdata (ram_rdata)
  );

  always_comb begin
    ack_d   = serve;
    rdata_d = (serve && !head.we) ? ram_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_ack   = ack_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/dpr_responder_checker.sv
module dpr_responder_checker #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned LVL_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              overlap_en,
  input logic              ack,
  input logic [DATA_W-1:0] rdata,
  input logic [LVL_W-1:0]  level
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= int'(DEPTH)); // R8

  AST_SINGLE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!overlap_en && !$past(overlap_en) && ($past(level) <= 1)) |-> (level <= 1)); // R6

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |-> (rdata == '0)); // R4

  AST_ACK_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(level) != '0)); // R4

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == int'($past(level))) ||
    (int'(level) == int'($past(level)) + 1) ||
    (int'(level) + 1 == int'($past(level)))); // R7

endmodule

bind dpr_responder dpr_responder_checker #(
  .DEPTH  (QDEPTH),
  .LVL_W  (LVL_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .overlap_en (overlap_en),
  .ack        (rsp_ack),
  .rdata      (rsp_rdata),
  .level      (q_level)
);

// File: tb/dpr_responder_test.sv
`timescale 1ns/1ps
module dpr_responder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        overlap_en = 1'b0;
  logic [3:0]  latency = '0;
  logic        req_stb = 1'b0;
  logic        req_we = 1'b0;
  logic [3:0]  req_bsel = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ack;
  logic [31:0] rsp_rdata;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_ack = 0;
  int ack_cyc [16];
  logic [31:0] ack_dat [16];

  always #10 clk = ~clk;

  dpr_responder uut (
    .clk(clk), .rst_n(rst_n), .overlap_en(overlap_en), .latency(latency),
    .req_stb(req_stb), .req_we(req_we), .req_bsel(req_bsel), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rsp_ack && n_ack < 16) begin
      ack_cyc[n_ack] = cyc;
      ack_dat[n_ack] = rsp_rdata;
      n_ack = n_ack + 1;
    end
  end

  // we[78] bsel[77:74] addr[73:68] wdata[67:36] lat[35:32] expected[31:0]
  localparam logic [78:0] VEC [10] = '{
    {1'b1, 4'hF, 6'd3,  32'h11223344, 4'd0,  32'h00000000},
    {1'b0, 4'h1, 6'd3,  32'h00000000, 4'd0,  32'h11223344},
    {1'b1, 4'h5, 6'd3,  32'hAABBCCDD, 4'd3,  32'h00000000},
    {1'b0, 4'hF, 6'd3,  32'h00000000, 4'd2,  32'h11BB33DD},
    {1'b1, 4'hF, 6'd63, 32'hDEADBEEF, 4'd15, 32'h00000000},
    {1'b0, 4'h2, 6'd63, 32'h00000000, 4'd15, 32'hDEADBEEF},
    {1'b1, 4'h0, 6'd63, 32'h00000000, 4'd1,  32'h00000000},
    {1'b0, 4'hF, 6'd63, 32'h00000000, 4'd1,  32'hDEADBEEF},
    {1'b1, 4'hA, 6'd63, 32'h12345678, 4'd0,  32'h00000000},
    {1'b0, 4'h8, 6'd63, 32'h00000000, 4'd0,  32'h12AD56EF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] sel, input logic [5:0] adr, input logic [31:0] wd);
    req_stb = 1'b1; req_we = we; req_bsel = sel; req_addr = adr; req_wdata = wd;
  endtask

  task automatic txn(input logic [78:0] v, input string req);
    int lat;
    bit quiet;
    lat = int'(v[35:32]);
    latency = v[35:32];
    quiet = 1'b1;
    drive(v[78], v[77:74], v[73:68], v[67:36]);
    for (int i = 1; i <= lat + 2; i++) begin
      @(negedge clk);
      if (i == 1) req_stb = 1'b0;
      if (i < lat + 2 && (rsp_ack || rsp_rdata != 0)) quiet = 1'b0;
    end
    chk(quiet && rsp_ack, "R5 ack cycle", {31'b0, rsp_ack}, 32'h1);
    chk(rsp_rdata == v[31:0], req, rsp_rdata, v[31:0]);
    @(negedge clk);
    chk(!rsp_ack && rsp_rdata == 0, "R4 single pulse", {31'b0, rsp_ack}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(!rsp_ack && rsp_rdata == 0, "R1 in reset", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rsp_ack && rsp_rdata == 0, "R1 after reset", rsp_rdata, 32'h0);

    foreach (VEC[k]) txn(VEC[k], "R2_R3 data");

    // R6: second strobe while one pending, overlap low
    overlap_en = 1'b0; latency = 4'd4; n_ack = 0; s = cyc;
    drive(1'b0, 4'hF, 6'd3, 32'h0);
    @(negedge clk); drive(1'b1, 4'hF, 6'd3, 32'hFFFFFFFF);
    @(negedge clk); req_stb = 1'b0;
    repeat (14) @(negedge clk); #1;
    chk(n_ack == 1, "R6 ack count", n_ack, 1);
    chk(ack_cyc[0] == s + 6 && ack_dat[0] == 32'h11BB33DD, "R6 first ack", ack_dat[0], 32'h11BB33DD);
    txn({1'b0, 4'hF, 6'd3, 32'h0, 4'd0, 32'h11BB33DD}, "R6 no write");

    // R7: two queued reads, overlap high
    overlap_en = 1'b1; latency = 4'd3; n_ack = 0; s = cyc;
    drive(1'b0, 4'hF, 6'd3, 32'h0);
    @(negedge clk); drive(1'b0, 4'hF, 6'd63, 32'h0);
    @(negedge clk); req_stb = 1'b0;
    repeat (12) @(negedge clk); #1;
    chk(n_ack == 2, "R7 ack count", n_ack, 2);
    chk(ack_cyc[0] == s + 5 && ack_dat[0] == 32'h11BB33DD, "R7 first in order", ack_dat[0], 32'h11BB33DD);
    chk(ack_cyc[1] == s + 9 && ack_dat[1] == 32'h12AD56EF, "R7 second in order", ack_dat[1], 32'h12AD56EF);

    // R8: third strobe while two pending
    latency = 4'd3; n_ack = 0; s = cyc;
    drive(1'b0, 4'hF, 6'd3, 32'h0);
    @(negedge clk); drive(1'b1, 4'hF, 6'd3, 32'h00000000);
    @(negedge clk); drive(1'b1, 4'hF, 6'd3, 32'hFFFFFFFF);
    @(negedge clk); req_stb = 1'b0;
    repeat (12) @(negedge clk); #1;
    chk(n_ack == 2, "R8 ack count", n_ack, 2);
    chk(ack_cyc[1] == s + 9 && ack_dat[1] == 32'h0, "R4 write ack data", ack_dat[1], 32'h0);
    txn({1'b0, 4'hF, 6'd3, 32'h0, 4'd0, 32'h00000000}, "R8 third dropped");

    // R9: strobe in the ack cycle, overlap low
    overlap_en = 1'b0; latency = 4'd0; n_ack = 0; s = cyc;
    drive(1'b0, 4'hF, 6'd63, 32'h0);
    @(negedge clk); req_stb = 1'b0;
    @(negedge clk); drive(1'b0, 4'hF, 6'd3, 32'h0);
    @(negedge clk); req_stb = 1'b0;
    repeat (4) @(negedge clk); #1;
    chk(n_ack == 2, "R9 ack count", n_ack, 2);
    chk(ack_cyc[1] == s + 4 && ack_dat[1] == 32'h0, "R9 accepted", ack_cyc[1], s + 4);

    // R1: reset while a request is pending
    overlap_en = 1'b1; latency = 4'd10; n_ack = 0;
    @(negedge clk); drive(1'b0, 4'hF, 6'd63, 32'h0);
    @(negedge clk); req_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rsp_ack && rsp_rdata == 0, "R1 reset mid flight", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (15) @(negedge clk); #1;
    chk(n_ack == 0, "R1 pending dropped", n_ack, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule